// File: doc/BRIEF.md
# Pixel Front-End Blank Alignment

This block is the first stage of a palette-based video output path. Two sets of timing controls reach it. Each set carries a blank, a vertical sync and a horizontal sync. The legacy set comes with an 8-bit pseudo-color byte. The system set serves the modes that feed a wide pixel bus. A mode bit picks which set is registered. After reset the legacy set is active, so the path works with no configuration at all.

A timing bit picks how blank relates to pixel data. With the bit clear, the first inactive blank sample and the first pixel group arrive on the same clock edge. Blank and pixels then leave the block together one cycle later. With the bit set, the first pixel group arrives two cycles after blank is first sampled inactive, because the shift clock has to start first. The block then adds two pipeline stages to blank, the syncs, the bypass select and the legacy byte, so they stay lined up with the pixel group. In this mode the block also drives a shift-clock enable.

The per-pixel bypass select tells the downstream logic to skip the palette lookup and use direct color. It is the OR of a direct-color bit and a color-key result. All configuration is taken in only while the selected blank is active, so a setting never changes partway through a line.

Top module: `pfe_blank_align`

## Requirements
- R1: While reset is held, and on its release, the outputs are: blank 1 (blanking active), both syncs 0, bypass 0, shift-clock enable 0, pixel group 0. The configuration is: legacy set selected, same-edge timing, direct color off, key enable field all zeros.
- R2: With the mode bit at 0 (the reset value) the legacy blank, vsync, hsync and pseudo-color byte sampled on a clock edge appear on the outputs right after that edge. No configuration input needs to change for this.
- R3: With the mode bit at 1 the system blank, vsync and hsync are used instead, with the same one-cycle latency.
- R4: With the timing bit at 0, the pixel group sampled on an edge appears right after that edge, in the same cycle as the blank sampled on that edge.
- R5: With the timing bit at 1, blank, both syncs, the bypass select and the legacy byte take two more cycles. The pixel group keeps its one-cycle latency. So a blank-inactive sample taken at edge k leaves the block together with the pixel group sampled at edge k+2.
- R6: With the timing bit at 1, the shift-clock enable is 1 from the edge where blank is first sampled inactive up to the edge where blank is sampled active again. With the timing bit at 0 it stays 0.
- R7: The bypass select is (direct-color bit) OR (key enable field nonzero AND key hit input). It goes through the same delay as blank.
- R8: A key enable field of all zeros forces the color-key part of bypass to 0, whatever the key hit input is.
- R9: The mode bit, timing bit, direct-color bit and key enable field are loaded only on edges where the currently selected blank input is 1. On other edges they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSysIn | input | 1 | Mode bit: 1 selects the system control set |
| cfgLateIn | input | 1 | Timing bit: 1 selects the two-cycle blank-to-pixel gap |
| cfgDirectIn | input | 1 | Direct-color bit |
| keyEnIn | input | KEY_W | Color-key enable field |
| legBlank | input | 1 | Legacy blank, 1 = blanking |
| legVsync | input | 1 | Legacy vertical sync |
| legHsync | input | 1 | Legacy horizontal sync |
| legPix | input | LEG_W | Legacy pseudo-color byte |
| sysBlank | input | 1 | System blank, 1 = blanking |
| sysVsync | input | 1 | System vertical sync |
| sysHsync | input | 1 | System horizontal sync |
| pixGroup | input | PIX_W | Wide pixel group |
| keyHit | input | 1 | Color-key comparison result for the current pixel |
| outBlank | output | 1 | Aligned blank |
| outVsync | output | 1 | Aligned vertical sync |
| outHsync | output | 1 | Aligned horizontal sync |
| outLegPix | output | LEG_W | Aligned legacy byte |
| outPixGroup | output | PIX_W | Registered pixel group |
| outBypass | output | 1 | 1 = skip the palette, use direct color |
| shiftEn | output | 1 | Shift-clock enable |

## Verification
The bench builds the block with a 32-bit pixel group, an 8-bit legacy byte and a 5-bit key field. The narrower bus keeps each pixel pattern short enough to write out. It still shows whether the pixel path, unlike the control path, bypasses the extra stages. The two-stage gap is fixed. The late-timing sequence therefore walks through every stage cycle by cycle. It checks that blank, vsync and the first pixel group come out on the same cycle, and that the shift-clock enable starts and stops on the sampled blank edges.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  // Cycles between first inactive blank sample and first pixel group in late timing
  localparam int LATE_GAP = 2;

  // Settings handed from control to datapath
  typedef struct packed {
    logic useSys;
    logic lateMode;
    logic directOn;
    logic keyOn;
  } pfeCfg_t;

endpackage

// File: rtl/pfe_ctrl.sv
module pfe_ctrl
  import pfe_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSysIn,
  input  logic             cfgLateIn,
  input  logic             cfgDirectIn,
  input  logic [KEY_W-1:0] keyEnIn,
  input  logic             selBlank,
  input  logic             stage0Blank,
  output pfeCfg_t          cfg,
  output logic             shiftEn
);

  logic             sysQ;
  logic             lateQ;
  logic             directQ;
  logic [KEY_W-1:0] keyEnQ;

  // Settings move only while the selected blank is active
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysQ    <= 1'b0;
      lateQ   <= 1'b0;
      directQ <= 1'b0;
      keyEnQ  <= '0;
    end else if (selBlank) begin
      sysQ    <= cfgSysIn;
      lateQ   <= cfgLateIn;
      directQ <= cfgDirectIn;
      keyEnQ  <= keyEnIn;
    end
  end

  always_comb begin
    cfg.useSys   = sysQ;
    cfg.lateMode = lateQ;
    cfg.directOn = directQ;
    cfg.keyOn    = |keyEnQ;
  end

  // Shift clock runs once blank has been sampled inactive, late timing only
  assign shiftEn = lateQ & ~stage0Blank;

endmodule

// File: rtl/pfe_datapath.sv
module pfe_datapath
  import pfe_pkg::*;
#(
  parameter int PIX_W = 128,
  parameter int LEG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pfeCfg_t          cfg,
  input  logic             legBlank,
  input  logic             legVsync,
  input  logic             legHsync,
  input  logic [LEG_W-1:0] legPix,
  input  logic             sysBlank,
  input  logic             sysVsync,
  input  logic             sysHsync,
  input  logic [PIX_W-1:0] pixGroup,
  input  logic             keyHit,
  output logic             selBlank,
  output logic             stage0Blank,
  output logic             outBlank,
  output logic             outVsync,
  output logic             outHsync,
  output logic [LEG_W-1:0] outLegPix,
  output logic [PIX_W-1:0] outPixGroup,
  output logic             outBypass
);

  localparam int STAGES = LATE_GAP + 1;

  typedef struct packed {
    logic             blank;
    logic             vs;
    logic             hs;
    logic             bypass;
    logic [LEG_W-1:0] pix;
  } ctlWord_t;

  localparam ctlWord_t RST_WORD = '{blank: 1'b1, vs: 1'b0, hs: 1'b0, bypass: 1'b0, pix: '0};

  ctlWord_t nextWord;
  ctlWord_t outWord;
  ctlWord_t stageQ [STAGES];
  logic [PIX_W-1:0] pixQ;

  always_comb begin
    nextWord.blank  = cfg.useSys ? sysBlank : legBlank;
    nextWord.vs     = cfg.useSys ? sysVsync : legVsync;
    nextWord.hs     = cfg.useSys ? sysHsync : legHsync;
    nextWord.bypass = cfg.directOn | (cfg.keyOn & keyHit);
    nextWord.pix    = legPix;
  end

  assign selBlank = nextWord.blank;

  // Control word pipeline: stage 0 always, extra stages for late timing
  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_WORD;
        else       stageQ[g] <= nextWord;
      end
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_WORD;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  // Pixel group is registered once in both timing modes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixQ <= '0;
    else       pixQ <= pixGroup;
  end

  assign stage0Blank = stageQ[0].blank;
  assign outWord     = cfg.lateMode ? stageQ[STAGES-1] : stageQ[0];

  assign outBlank    = outWord.blank;
  assign outVsync    = outWord.vs;
  assign outHsync    = outWord.hs;
  assign outBypass   = outWord.bypass;
  assign outLegPix   = outWord.pix;
  assign outPixGroup = pixQ;

endmodule

// File: rtl/pfe_blank_align.sv
module pfe_blank_align
  import pfe_pkg::*;
#(
  parameter int PIX_W = 128,
  parameter int LEG_W = 8,
  parameter int KEY_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSysIn,
  input  logic             cfgLateIn,
  input  logic             cfgDirectIn,
  input  logic [KEY_W-1:0] keyEnIn,
  input  logic             legBlank,
  input  logic             legVsync,
  input  logic             legHsync,
  input  logic [LEG_W-1:0] legPix,
  input  logic             sysBlank,
  input  logic             sysVsync,
  input  logic             sysHsync,
  input  logic [PIX_W-1:0] pixGroup,
  input  logic             keyHit,
  output logic             outBlank,
  output logic             outVsync,
  output logic             outHsync,
  output logic [LEG_W-1:0] outLegPix,
  output logic [PIX_W-1:0] outPixGroup,
  output logic             outBypass,
  output logic             shiftEn
);

  pfeCfg_t cfgWord;
  logic    selBlank;
  logic    stage0Blank;

  pfe_ctrl #(.KEY_W(KEY_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgSysIn    (cfgSysIn),
    .cfgLateIn   (cfgLateIn),
    .cfgDirectIn (cfgDirectIn),
    .keyEnIn     (keyEnIn),
    .selBlank    (selBlank),
    .stage0Blank (stage0Blank),
    .cfg         (cfgWord),
    .shiftEn     (shiftEn)
  );

  pfe_datapath #(.PIX_W(PIX_W), .LEG_W(LEG_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cfg         (cfgWord),
    .legBlank    (legBlank),
    .legVsync    (legVsync),
    .legHsync    (legHsync),
    .legPix      (legPix),
    .sysBlank    (sysBlank),
    .sysVsync    (sysVsync),
    .sysHsync    (sysHsync),
    .pixGroup    (pixGroup),
    .keyHit      (keyHit),
    .selBlank    (selBlank),
    .stage0Blank (stage0Blank),
    .outBlank    (outBlank),
    .outVsync    (outVsync),
    .outHsync    (outHsync),
    .outLegPix   (outLegPix),
    .outPixGroup (outPixGroup),
    .outBypass   (outBypass)
  );

endmodule

// File: rtl/pfe_blank_align_chk.sv
module pfe_blank_align_chk
  import pfe_pkg::*;
#(
  parameter int PIX_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input pfeCfg_t          cfg,
  input logic             selBlank,
  input logic             stage0Blank,
  input logic             outBlank,
  input logic [PIX_W-1:0] pixGroup,
  input logic [PIX_W-1:0] outPixGroup,
  input logic             shiftEn
);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(selBlank)) |-> $stable(cfg));

  // R4
  same_edge_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !cfg.lateMode) |-> outBlank == $past(selBlank));

  // R4
  pix_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outPixGroup == $past(pixGroup));

  // R5
  late_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 3) && cfg.lateMode && $past(cfg.lateMode) && $past(cfg.lateMode, 2))
      |-> outBlank == $past(stage0Blank, 2));

  // R6
  shift_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(shiftEn)) |-> (cfg.lateMode && !$past(selBlank)));

endmodule

bind pfe_blank_align pfe_blank_align_chk #(.PIX_W(PIX_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cfg         (cfgWord),
  .selBlank    (selBlank),
  .stage0Blank (stage0Blank),
  .outBlank    (outBlank),
  .pixGroup    (pixGroup),
  .outPixGroup (outPixGroup),
  .shiftEn     (shiftEn)
);

// File: tb/pfe_blank_align_test.sv
`timescale 1ns/100ps
module pfe_blank_align_test;

  localparam int PIX_W = 32;
  localparam int LEG_W = 8;
  localparam int KEY_W = 5;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cfgSysIn, cfgLateIn, cfgDirectIn;
  logic [KEY_W-1:0] keyEnIn;
  logic             legBlank, legVsync, legHsync;
  logic [LEG_W-1:0] legPix;
  logic             sysBlank, sysVsync, sysHsync;
  logic [PIX_W-1:0] pixGroup;
  logic             keyHit;
  logic             outBlank, outVsync, outHsync, outBypass, shiftEn;
  logic [LEG_W-1:0] outLegPix;
  logic [PIX_W-1:0] outPixGroup;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  pfe_blank_align #(.PIX_W(PIX_W), .LEG_W(LEG_W), .KEY_W(KEY_W)) uut (
    .clk(clk), .rstN(rstN), .cfgSysIn(cfgSysIn), .cfgLateIn(cfgLateIn),
    .cfgDirectIn(cfgDirectIn), .keyEnIn(keyEnIn), .legBlank(legBlank),
    .legVsync(legVsync), .legHsync(legHsync), .legPix(legPix),
    .sysBlank(sysBlank), .sysVsync(sysVsync), .sysHsync(sysHsync),
    .pixGroup(pixGroup), .keyHit(keyHit), .outBlank(outBlank),
    .outVsync(outVsync), .outHsync(outHsync), .outLegPix(outLegPix),
    .outPixGroup(outPixGroup), .outBypass(outBypass), .shiftEn(shiftEn)
  );

  typedef struct packed {
    logic             lb, lv, lh;
    logic [LEG_W-1:0] lp;
    logic             sb, sv, sh;
    logic [PIX_W-1:0] pg;
    logic             eb, ev, eh;
    logic [LEG_W-1:0] ep;
    logic [PIX_W-1:0] epg;
  } vec_t;

  // Legacy set, same-edge timing: outputs follow the legacy inputs, system set ignored
  localparam vec_t VECS [6] = '{
    '{1,1,0,8'h11, 0,0,1,32'hA0A0A0A0, 1,1,0,8'h11,32'hA0A0A0A0},
    '{0,0,1,8'h22, 1,1,0,32'h00000001, 0,0,1,8'h22,32'h00000001},
    '{0,1,1,8'h33, 1,0,0,32'hFFFFFFFF, 0,1,1,8'h33,32'hFFFFFFFF},
    '{1,0,0,8'hC4, 0,1,1,32'h12345678, 1,0,0,8'hC4,32'h12345678},
    '{0,0,0,8'h5A, 1,1,1,32'h80000000, 0,0,0,8'h5A,32'h80000000},
    '{1,1,1,8'hFF, 0,0,0,32'h0F0F0F0F, 1,1,1,8'hFF,32'h0F0F0F0F}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20000 * 5);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    rstN = 1'b0;
    cfgSysIn = 0; cfgLateIn = 0; cfgDirectIn = 0; keyEnIn = '0;
    legBlank = 1; legVsync = 0; legHsync = 0; legPix = '0;
    sysBlank = 1; sysVsync = 0; sysHsync = 0; pixGroup = '0; keyHit = 0;
    repeat (5) tick();

    // R1 reset state
    chk("R1 blank", outBlank, 1);
    chk("R1 vsync", outVsync, 0);
    chk("R1 hsync", outHsync, 0);
    chk("R1 bypass", outBypass, 0);
    chk("R1 shiftEn", shiftEn, 0);
    chk("R1 pixGroup", outPixGroup, 0);
    rstN = 1'b1;
    tick();

    // R2 / R4 table walk with no configuration written
    foreach (VECS[i]) begin
      legBlank = VECS[i].lb; legVsync = VECS[i].lv; legHsync = VECS[i].lh; legPix = VECS[i].lp;
      sysBlank = VECS[i].sb; sysVsync = VECS[i].sv; sysHsync = VECS[i].sh; pixGroup = VECS[i].pg;
      tick();
      chk("R2 blank", outBlank, VECS[i].eb);
      chk("R2 vsync", outVsync, VECS[i].ev);
      chk("R2 hsync", outHsync, VECS[i].eh);
      chk("R2 legPix", outLegPix, VECS[i].ep);
      chk("R4 pixGroup", outPixGroup, VECS[i].epg);
      chk("R6 shiftEn off in same-edge timing", shiftEn, 0);
    end

    // R9 settings ignored while legacy blank inactive
    legBlank = 0; legVsync = 0; legHsync = 0;
    sysBlank = 0; sysVsync = 1; sysHsync = 1;
    cfgSysIn = 1; cfgDirectIn = 1;
    tick();
    chk("R9 vsync stays legacy", outVsync, 0);
    chk("R9 bypass stays off", outBypass, 0);
    tick();
    chk("R9 vsync stays legacy again", outVsync, 0);
    legBlank = 1;
    tick();
    chk("R9 load edge still legacy", outVsync, 0);
    tick();
    // R3 system set now drives, R7 direct bit forces bypass
    chk("R3 system blank", outBlank, 0);
    chk("R3 system vsync", outVsync, 1);
    chk("R3 system hsync", outHsync, 1);
    chk("R7 direct bypass", outBypass, 1);

    // R8 / R7 color key
    sysBlank = 1; sysVsync = 0; sysHsync = 0;
    cfgDirectIn = 0; keyEnIn = '0; keyHit = 1;
    tick();
    tick();
    chk("R8 zero key field blocks hit", outBypass, 0);
    keyEnIn = 5'b00100;
    tick();
    tick();
    chk("R7 key hit bypass", outBypass, 1);
    keyHit = 0;
    tick();
    chk("R7 key miss no bypass", outBypass, 0);
    keyEnIn = '0;

    // R5 / R6 late timing
    cfgLateIn = 1;
    repeat (4) tick();
    chk("R6 shiftEn idle in blank", shiftEn, 0);
    chk("R5 blank active", outBlank, 1);
    sysBlank = 0; sysVsync = 1; pixGroup = 32'hDEAD0001;
    tick();
    chk("R6 shiftEn starts", shiftEn, 1);
    chk("R5 blank held k", outBlank, 1);
    sysVsync = 0; pixGroup = 32'hDEAD0002;
    tick();
    chk("R5 blank held k+1", outBlank, 1);
    pixGroup = 32'hC0FFEE01;
    tick();
    chk("R5 blank aligned", outBlank, 0);
    chk("R5 vsync aligned", outVsync, 1);
    chk("R5 first pixel", outPixGroup, 32'hC0FFEE01);
    sysBlank = 1; pixGroup = '0;
    tick();
    chk("R6 shiftEn stops", shiftEn, 0);
    chk("R5 blank still open", outBlank, 0);
    tick();
    chk("R5 blank open last", outBlank, 0);
    tick();
    chk("R5 blank closes", outBlank, 1);

    finished = 1'b1;
    finish_run();
  end

endmodule